// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block is a first-in first-out buffer that sits between two unrelated clock domains. Words of 9 bits enter on the write clock and leave on the read clock. Neither clock has to be the faster one. Each pointer crosses into the other domain as a Gray code through a two-stage synchronizer. The depth is 2^AW words. The default of 16 words keeps simulation quick.

The read-timing style is sampled from `mode_sel` while master reset is held low, and it then stays fixed until the next master reset. After reset the block ignores `mode_sel`; that pin is left free for serial offset loading, which another block handles.

- **Standard style.** The read side shows an empty flag. Each word must be requested with `rd_ready`. The word appears on `rd_data` one read clock later, and `rd_valid` pulses for that cycle.
- **Fall-through style.** The first available word moves to `rd_data` without any request. `rd_flag` acts as output-ready. The read port then behaves as valid/ready: a word is consumed on a read-clock edge where `rd_valid` and `rd_ready` are both high.

Write back-pressure follows valid/ready rules. A word is taken on a write-clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the FIFO is full, and `wr_valid` seen during that time is dropped.

Partial reset empties the buffer but keeps the latched timing style. The almost-empty and almost-full thresholds come from a separate register block as plain inputs.

A rewind strobe on the read side moves the read pointer back to the first word written since the last reset. This lets that data be read out again. The write side must stay idle during a rewind, and no more than the depth may have been written since that reset.

Top module: `twf_fifo`

## Requirements
- R1: While `mrst_n` is low, `mode_sel` is latched: 0 selects the standard style and 1 selects fall-through. The latched style stays in force after release, whatever `mode_sel` does afterwards, until the next master reset.
- R2: After master reset, `rd_valid` is 0 and `half_full` is 0. In standard style `rd_flag` is 1 (empty) and `wr_flag` is 0 (not full). In fall-through style `rd_flag` is 0 (not ready) and `wr_flag` is 1 (room available). `wr_ready` is 1 in both styles.
- R3: Words are read out in the order they were written, with their values unchanged.
- R4: While the FIFO holds 2^AW words, `wr_ready` is 0 and standard `wr_flag` is 1. A write attempted then is dropped, and the dropped word never appears on the read side.
- R5: In standard style, a read request while empty leaves `rd_data` unchanged and `rd_valid` at 0.
- R6: In fall-through style, a word written into an empty FIFO appears on `rd_data` with `rd_flag` and `rd_valid` high on the third read-clock edge after the write edge. No read request is needed. The word then holds until it is consumed.
- R7: In standard style, the empty flag falls on the second read-clock edge after a write into an empty FIFO. A request accepted on an edge puts the word on `rd_data`, and `rd_valid` is high for the cycle after that edge.
- R8: `half_full` is 1 exactly when the write side sees more than 2^(AW-1) words stored.
- R9: `almost_full` is 1 when the write-side count is at least 2^AW minus `af_level`. `almost_empty` is 1 when the read-side count of stored, not yet fetched words is at most `ae_level`.
- R10: Holding `prst_n` low empties the FIFO and keeps the latched timing style.
- R11: A one-cycle `rd_rewind` returns the read side to the first word written since the last reset. In standard style the empty flag is low on the very next read-clock edge, and the same words can then be read again in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock, independent of wr_clk |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert; also latches the style |
| prst_n | input | 1 | Partial reset, active low; clears pointers, keeps style |
| mode_sel | input | 1 | Style select sampled during master reset (1 = fall-through) |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Space available; a write happens when both are high |
| wr_data | input | DW | Word to store |
| wr_flag | output | 1 | Standard: full; fall-through: input ready |
| half_full | output | 1 | More than half of the locations occupied |
| af_level | input | AW | Almost-full distance from the top |
| almost_full | output | 1 | Occupancy at or above depth minus af_level |
| rd_ready | input | 1 | Read request / consume |
| rd_valid | output | 1 | Standard: pulse after a fetch; fall-through: word held on output |
| rd_data | output | DW | Output word register |
| rd_flag | output | 1 | Standard: empty; fall-through: output ready |
| rd_rewind | input | 1 | Retransmit strobe on the read clock |
| ae_level | input | AW | Almost-empty threshold |
| almost_empty | output | 1 | Read-side count at or below ae_level |

## Verification
A full sweep writes one word at a time until the FIFO is full, then reads one word at a time until it is empty. Every word has a distinct value, so reordering or loss shows up, and the flag thresholds are checked at every occupancy. A single write into an empty FIFO is timed in read-clock edges in both styles, with clock periods that never align, so the separate synchronizer latency of each style is confirmed. Attempts on a full or an empty FIFO, a fall-through stall with words queued behind the output, a rewind and replay, and partial resets in each style separate the cases of dropped, held, replayed and preserved state.

// File: rtl/twf_pkg.sv
package twf_pkg;
  typedef enum logic {
    TM_STD  = 1'b0,
    TM_FWFT = 1'b1
  } tmode_e;
endpackage

// File: rtl/twf_sync.sv
module twf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/twf_mem.sv
module twf_mem #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/twf_wr_side.sv
module twf_wr_side
  import twf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          mode_sel,
  input  logic          wr_valid,
  input  logic [AW:0]   rgray_s,
  input  logic [AW-1:0] af_level,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          wr_ready,
  output logic          wr_flag,
  output logic          half_full,
  output logic          almost_full,
  output logic          fwft
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  tmode_e        mode_q;
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] used;
  logic [PW-1:0] wbin_n;
  logic          full;

  // style latched only while master reset is held
  always_ff @(posedge wr_clk) begin
    if (!mrst_n) mode_q <= tmode_e'(mode_sel);
  end

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign used   = wbin - rbin_s;
  assign full   = used[AW];
  assign push   = wr_valid & ~full;
  assign wbin_n = wbin + PW'(1);

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
    end
  end

  assign waddr       = wbin[AW-1:0];
  assign fwft        = (mode_q == TM_FWFT);
  assign wr_ready    = ~full;
  assign wr_flag     = fwft ? ~full : full;
  assign half_full   = (used > PW'(HALF));
  assign almost_full = (used >= (PW'(DEPTH) - PW'(af_level)));
endmodule

// File: rtl/twf_rd_side.sv
module twf_rd_side
  import twf_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          mode_sel,
  input  logic          rd_ready,
  input  logic          rd_rewind,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_level,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_flag,
  output logic          almost_empty,
  output logic          fwft
);
  localparam int PW = AW + 1;

  tmode_e        mode_q;
  logic [PW-1:0] wbin_s;
  logic [PW-1:0] used;
  logic [PW-1:0] rbin_n;
  logic          empty;
  logic          out_v;
  logic          pop;

  always_ff @(posedge rd_clk) begin
    if (!mrst_n) mode_q <= tmode_e'(mode_sel);
  end

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign fwft   = (mode_q == TM_FWFT);
  assign used   = wbin_s - rbin;
  assign empty  = (used == '0);
  assign pop    = ~empty & (fwft ? (~out_v | rd_ready) : rd_ready);
  assign rbin_n = rbin + PW'(1);

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      out_v <= 1'b0;
    end else if (rd_rewind) begin
      rbin  <= '0;
      rgray <= '0;
      out_v <= 1'b0;
    end else begin
      if (pop) begin
        rbin  <= rbin_n;
        rgray <= rbin_n ^ (rbin_n >> 1);
      end
      out_v <= pop | (fwft & out_v & ~rd_ready);
    end
  end

  always_ff @(posedge rd_clk or negedge mrst_n) begin
    if (!mrst_n)                 rd_data <= '0;
    else if (pop && !rd_rewind)  rd_data <= mem_q;
  end

  assign raddr        = rbin[AW-1:0];
  assign rd_valid     = out_v;
  assign rd_flag      = fwft ? out_v : empty;
  assign almost_empty = (used <= PW'(ae_level));
endmodule

// File: rtl/twf_fifo.sv
module twf_fifo #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_sel,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          wr_flag,
  output logic          half_full,
  input  logic [AW-1:0] af_level,
  output logic          almost_full,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag,
  input  logic          rd_rewind,
  input  logic [AW-1:0] ae_level,
  output logic          almost_empty
);
  localparam int PW = AW + 1;

  logic          rst_n_ptr;
  logic          push;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [PW-1:0] wbin;
  logic [PW-1:0] wgray;
  logic [PW-1:0] rbin;
  logic [PW-1:0] rgray;
  logic [PW-1:0] wgray_s;
  logic [PW-1:0] rgray_s;
  logic [DW-1:0] mem_q;
  logic          fwft_w;
  logic          fwft_r;

  assign rst_n_ptr = mrst_n & prst_n;

  twf_mem #(.AW(AW), .DW(DW)) u_mem (
    .wclk  (wr_clk),
    .we    (push),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (mem_q)
  );

  twf_sync #(.W(PW)) u_r2w (
    .clk   (wr_clk),
    .rst_n (rst_n_ptr),
    .d     (rgray),
    .q     (rgray_s)
  );

  twf_sync #(.W(PW)) u_w2r (
    .clk   (rd_clk),
    .rst_n (rst_n_ptr),
    .d     (wgray),
    .q     (wgray_s)
  );

  twf_wr_side #(.AW(AW)) u_wr (
    .wr_clk      (wr_clk),
    .rst_n       (rst_n_ptr),
    .mrst_n      (mrst_n),
    .mode_sel    (mode_sel),
    .wr_valid    (wr_valid),
    .rgray_s     (rgray_s),
    .af_level    (af_level),
    .push        (push),
    .waddr       (waddr),
    .wbin        (wbin),
    .wgray       (wgray),
    .wr_ready    (wr_ready),
    .wr_flag     (wr_flag),
    .half_full   (half_full),
    .almost_full (almost_full),
    .fwft        (fwft_w)
  );

  twf_rd_side #(.AW(AW), .DW(DW)) u_rd (
    .rd_clk       (rd_clk),
    .rst_n        (rst_n_ptr),
    .mrst_n       (mrst_n),
    .mode_sel     (mode_sel),
    .rd_ready     (rd_ready),
    .rd_rewind    (rd_rewind),
    .wgray_s      (wgray_s),
    .ae_level     (ae_level),
    .mem_q        (mem_q),
    .raddr        (raddr),
    .rbin         (rbin),
    .rgray        (rgray),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .rd_flag      (rd_flag),
    .almost_empty (almost_empty),
    .fwft         (fwft_r)
  );
endmodule

// File: rtl/twf_chk.sv
module twf_chk #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          mrst_n,
  input logic          rst_n_ptr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          half_full,
  input logic          rd_ready,
  input logic          rd_valid,
  input logic          rd_flag,
  input logic          rd_rewind,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic          fwft_w,
  input logic          fwft_r
);
  // R1: latched style does not move outside master reset
  a_r1_mode_fixed: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    $stable(fwft_w));

  // R4: a refused write leaves the write pointer where it was
  a_r4_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n_ptr)
    (wr_valid && !wr_ready) |=> $stable(wbin));

  // R8: a full buffer is necessarily more than half full
  a_r8_full_is_half: assert property (@(posedge wr_clk) disable iff (!rst_n_ptr)
    !wr_ready |-> half_full);

  // R5: standard-style empty holds the read pointer
  a_r5_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n_ptr)
    (!fwft_r && rd_flag && !rd_rewind) |=> $stable(rbin));

  // R6: fall-through word held until consumed
  a_r6_hold_word: assert property (@(posedge rd_clk) disable iff (!rst_n_ptr)
    (fwft_r && rd_valid && !rd_ready && !rd_rewind) |=> (rd_valid && $stable(rd_data)));

  // R7: standard-style output only moves after an accepted request
  a_r7_data_on_request: assert property (@(posedge rd_clk) disable iff (!rst_n_ptr)
    (!fwft_r && !$stable(rd_data)) |-> $past(rd_ready && !rd_flag));
endmodule

bind twf_fifo twf_chk #(.AW(AW), .DW(DW)) u_chk (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .mrst_n    (mrst_n),
  .rst_n_ptr (rst_n_ptr),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .half_full (half_full),
  .rd_ready  (rd_ready),
  .rd_valid  (rd_valid),
  .rd_flag   (rd_flag),
  .rd_rewind (rd_rewind),
  .rd_data   (rd_data),
  .wbin      (wbin),
  .rbin      (rbin),
  .fwft_w    (fwft_w),
  .fwft_r    (fwft_r)
);

// File: tb/sim_twf_fifo.sv
`timescale 1ns/100ps
module sim_twf_fifo;
  localparam int AW    = 4;
  localparam int DW    = 9;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          mrst_n = 1'b0;
  logic          prst_n = 1'b1;
  logic          mode_sel = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic          wr_flag;
  logic          half_full;
  logic [AW-1:0] af_level = AW'(3);
  logic          almost_full;
  logic          rd_ready = 1'b0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          rd_flag;
  logic          rd_rewind = 1'b0;
  logic [AW-1:0] ae_level = AW'(2);
  logic          almost_empty;

  int n_chk = 0;
  int n_bad = 0;

  always #5 wr_clk = ~wr_clk;
  initial begin
    #2.5;
    forever #7 rd_clk = ~rd_clk;
  end

  twf_fifo #(.AW(AW), .DW(DW)) u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic master_reset(input logic m);
    @(negedge wr_clk);
    mrst_n = 1'b0;
    mode_sel = m;
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk);
    mrst_n = 1'b1;
    mode_sel = ~m;   // must have no effect after release
    settle();
  endtask

  task automatic partial_reset();
    @(negedge wr_clk);
    prst_n = 1'b0;
    repeat (3) @(negedge rd_clk);
    @(negedge wr_clk);
    prst_n = 1'b1;
    settle();
  endtask

  // drive a write; returns 1 ns after the write-clock edge
  task automatic put(input int d);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_data  = DW'(d);
    @(posedge wr_clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic take();
    @(negedge rd_clk);
    rd_ready = 1'b1;
    @(negedge rd_clk);
    rd_ready = 1'b0;
  endtask

  // read edges after the last write until rd_flag reaches target
  task automatic edges_until(input logic target, output int n);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge rd_clk);
      #1;
      n++;
      if (rd_flag == target) break;
    end
  endtask

  function automatic int fill_val(input int i);
    return (i * 37 + 5) % 512;
  endfunction

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    // ---------------- standard style ----------------
    master_reset(1'b0);
    check("R2 rd_flag empty", int'(rd_flag), 1);
    check("R2 wr_flag", int'(wr_flag), 0);
    check("R2 wr_ready", int'(wr_ready), 1);
    check("R2 half_full", int'(half_full), 0);
    check("R2 rd_valid", int'(rd_valid), 0);
    check("R9 almost_empty at 0", int'(almost_empty), 1);

    put(421);
    edges_until(1'b0, n);
    check("R7 empty falls after edges", n, 2);
    take();
    check("R7 rd_data", int'(rd_data), 421);
    check("R7 rd_valid pulse", int'(rd_valid), 1);
    check("R7 empty again", int'(rd_flag), 1);
    take();
    check("R5 rd_data kept", int'(rd_data), 421);
    check("R5 rd_valid low", int'(rd_valid), 0);

    // fill sweep (write count equals occupancy)
    for (int i = 0; i < DEPTH; i++) begin
      put(fill_val(i));
      check("R8 half_full", int'(half_full), int'((i + 1) > DEPTH / 2));
      check("R9 almost_full", int'(almost_full), int'((i + 1) >= DEPTH - 3));
    end
    check("R4 wr_flag full", int'(wr_flag), 1);
    check("R4 wr_ready low", int'(wr_ready), 0);
    put(255);   // dropped
    settle();
    check("R9 almost_empty when full", int'(almost_empty), 0);
    for (int i = 0; i < DEPTH; i++) begin
      take();
      check("R3 order", int'(rd_data), fill_val(i));
      check("R9 almost_empty", int'(almost_empty), int'((DEPTH - 1 - i) <= 2));
    end
    check("R4 dropped word absent", int'(rd_flag), 1);
    settle();
    check("R4 not full after drain", int'(wr_flag), 0);

    // rewind and replay
    partial_reset();
    check("R10 empty after partial", int'(rd_flag), 1);
    check("R10 standard kept", int'(wr_flag), 0);
    for (int i = 0; i < 5; i++) put((300 + i * 11) % 512);
    settle();
    for (int i = 0; i < 5; i++) begin
      take();
      check("R11 first pass", int'(rd_data), (300 + i * 11) % 512);
    end
    check("R11 empty before rewind", int'(rd_flag), 1);
    @(negedge rd_clk);
    rd_rewind = 1'b1;
    @(negedge rd_clk);
    rd_rewind = 1'b0;
    check("R11 data back next edge", int'(rd_flag), 0);
    for (int i = 0; i < 5; i++) begin
      take();
      check("R11 replay", int'(rd_data), (300 + i * 11) % 512);
    end

    // ---------------- fall-through style ----------------
    master_reset(1'b1);
    check("R2 R1 fwft rd_flag", int'(rd_flag), 0);
    check("R2 R1 fwft wr_flag ready", int'(wr_flag), 1);
    check("R2 fwft wr_ready", int'(wr_ready), 1);
    put(341);
    edges_until(1'b1, n);
    check("R6 fall-through edges", n, 3);
    check("R6 word shown", int'(rd_data), 341);
    check("R6 rd_valid", int'(rd_valid), 1);
    for (int i = 0; i < 3; i++) put((i * 101 + 7) % 512);
    settle();
    check("R6 held while stalled", int'(rd_data), 341);
    for (int i = 0; i < 3; i++) begin
      take();
      check("R3 fwft order", int'(rd_data), (i * 101 + 7) % 512);
    end
    take();
    check("R6 output drained", int'(rd_flag), 0);

    put(77);
    partial_reset();
    check("R10 fwft cleared", int'(rd_flag), 0);
    check("R10 fwft kept", int'(wr_flag), 1);
    put(99);
    settle();
    check("R10 R1 word without request", int'(rd_data), 99);
    check("R10 output ready", int'(rd_flag), 1);

    master_reset(1'b0);
    check("R1 back to standard", int'(rd_flag), 1);
    check("R1 standard wr_flag", int'(wr_flag), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule